// File: doc/BRIEF.md
# BCD Calendar Timekeeping Chain

This block keeps wall-clock time and the calendar date as packed BCD fields: seconds, minutes, hours, a day-of-week index, day of month, month and a two-digit year. A one-cycle enable (`tick`) arrives once per second from an external prescaler. Each stage advances only when the stage below it wraps, so the carries act as enables on a single clock and nothing is clocked by a carry. The day-of-month stage takes its wrap point from a two-bit month-length code. That code is decoded from the current month and year, and leap Februaries follow the year's divisibility by four.

An external adjuster presets any stage through a one-hot select vector and a shared data byte. A preset takes priority over counting for the stage it selects, and a stage that is being preset emits no carry in that cycle. The year stage's wrap is brought out as a single-cycle `year_carry` pulse.

Top module: `cal_chain`

## Requirements
- R1: After reset the outputs read secs=8'h00, mins=8'h00, hours=8'h00, wday=3'd0, mday=8'h01, month=8'h01, year=8'h00, and year_carry is low.
- R2: Each clock with tick high advances secs by one in BCD, and 8'h59 goes to 8'h00 with a carry into minutes. Without tick, and without a load, secs holds its value.
- R3: Minutes advance on the seconds carry and go from 8'h59 to 8'h00 with a carry. Hours advance on the minutes carry and go from 8'h23 to 8'h00 with a carry into the weekday and day-of-month stages.
- R4: wday advances on the hours carry through 0..6 and goes from 6 back to 0.
- R5: mday advances on the hours carry in BCD, so the low digit goes from 9 to 0 and the tens digit increments (8'h09 to 8'h10). When mday is at or above the month's limit it returns to 8'h01 and carries into month.
- R6: The day limit comes from a 2-bit code: 2'b00 gives 28, 2'b01 gives 29, 2'b10 gives 30 and 2'b11 gives 31. Months 01, 03, 05, 07, 08, 10 and 12 give 31, and months 04, 06, 09 and 11 give 30. Month 02 gives 29 when the BCD year is divisible by 4 (00 included) and 28 otherwise.
- R7: month advances on the day carry and goes from 8'h12 to 8'h01 with a carry into year. year goes from 8'h99 to 8'h00, and year_carry is high during the same cycle as the clock edge that makes that wrap.
- R8: load_sel bit positions are 0 secs, 1 mins, 2 hours, 3 wday (takes load_val[2:0]), 4 mday, 5 month and 6 year. A set bit replaces that stage with load_val at the next edge, even when a carry into that stage arrives in the same cycle. A stage being loaded emits no carry in that cycle, so the stages above it hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| load_sel | input | 7 | Per-stage preset select |
| load_val | input | 8 | Preset value (BCD) |
| secs | output | 8 | Seconds, BCD |
| mins | output | 8 | Minutes, BCD |
| hours | output | 8 | Hours, BCD |
| wday | output | 3 | Day of week 0..6 |
| mday | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Two-digit year, BCD |
| year_carry | output | 1 | Pulse when year wraps 99 to 00 |

## Verification
A preset and a carry can target the same stage in one cycle. The bench provokes this by loading seconds while tick is high and seconds read 59, and by loading the day of month in the same cycle as a midnight rollover. The judgement is that the loaded value appears, the carry is dropped and the stages above stay unchanged. The month-length decode is also exercised at each month's last day, in common and leap years.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int DIGW    = 8;
    localparam int WDAYW   = 3;
    localparam int NSTAGE  = 7;
    localparam int NBCD    = 6;

    typedef enum logic [1:0] {
        MLEN_28 = 2'b00,
        MLEN_29 = 2'b01,
        MLEN_30 = 2'b10,
        MLEN_31 = 2'b11
    } mlen_e;

    function automatic logic [DIGW-1:0] bcd_inc(input logic [DIGW-1:0] v);
        logic [DIGW-1:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [DIGW-1:0] mlen_limit(input mlen_e c);
        logic [DIGW-1:0] r;
        unique case (c)
            MLEN_28: r = 8'h28;
            MLEN_29: r = 8'h29;
            MLEN_30: r = 8'h30;
            MLEN_31: r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_stage.sv
module cal_stage #(
    parameter int             W    = 8,
    parameter bit             BCD  = 1'b1,
    parameter logic [W-1:0]   MINV = '0,
    parameter logic [W-1:0]   RSTV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] max_val,
    output logic [W-1:0] q,
    output logic         co
);
    import cal_pkg::*;

    logic         at_max;
    logic [W-1:0] inc;

    generate
        if (BCD) begin : g_bcd
            assign inc = W'(bcd_inc(DIGW'(q)));
        end else begin : g_bin
            assign inc = q + W'(1);
        end
    endgenerate

    always_comb begin
        at_max = (q >= max_val);
        co     = cnt_en & ~ld & at_max;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RSTV;
        else if (ld)     q <= ld_val;
        else if (cnt_en) q <= at_max ? MINV : inc;
    end

endmodule

// File: rtl/cal_mlen.sv
module cal_mlen (
    input  logic [7:0]     mon,
    input  logic [7:0]     yr,
    output cal_pkg::mlen_e code
);
    import cal_pkg::*;

    logic [1:0] yr_mod4;
    logic       leap;

    always_comb begin
        // 10*t + u mod 4 equals 2*t[0] + u[1:0] mod 4
        yr_mod4 = {yr[4], 1'b0} + yr[1:0];
        leap    = (yr_mod4 == 2'd0);
        unique case (mon)
            8'h02:                      code = leap ? MLEN_29 : MLEN_28;
            8'h04, 8'h06, 8'h09, 8'h11: code = MLEN_30;
            default:                    code = MLEN_31;
        endcase
    end

endmodule

// File: rtl/cal_chain.sv
module cal_chain (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [6:0] load_sel,
    input  logic [7:0] load_val,
    output logic [7:0] secs,
    output logic [7:0] mins,
    output logic [7:0] hours,
    output logic [2:0] wday,
    output logic [7:0] mday,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic       year_carry
);
    import cal_pkg::*;

    // BCD stage order: 0 secs, 1 mins, 2 hours, 3 mday, 4 month, 5 year
    localparam logic [NBCD-1:0][DIGW-1:0] MAXC = {8'h99, 8'h12, 8'h00, 8'h23, 8'h59, 8'h59};
    localparam logic [NBCD-1:0][DIGW-1:0] MINC = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    localparam int WDAY_LD = 3;

    logic [NBCD-1:0][DIGW-1:0] q;
    logic [NBCD-1:0]           co;
    logic [NBCD-1:0]           en;
    logic [DIGW-1:0]           day_lim;
    mlen_e                     mcode;
    logic                      wday_co;

    cal_mlen u_mlen (
        .mon  (q[4]),
        .yr   (q[5]),
        .code (mcode)
    );

    assign day_lim = mlen_limit(mcode);

    assign en[0] = tick;
    assign en[NBCD-1:1] = co[NBCD-2:0];

    genvar k;
    generate
        for (k = 0; k < NBCD; k++) begin : g_stage
            localparam int LDX = (k < 3) ? k : k + 1;
            logic [DIGW-1:0] lim;
            if (k == 3) begin : g_dyn
                assign lim = day_lim;
            end else begin : g_fix
                assign lim = MAXC[k];
            end
            cal_stage #(
                .W    (DIGW),
                .BCD  (1'b1),
                .MINV (MINC[k]),
                .RSTV (MINC[k])
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .cnt_en  (en[k]),
                .ld      (load_sel[LDX]),
                .ld_val  (load_val),
                .max_val (lim),
                .q       (q[k]),
                .co      (co[k])
            );
        end
    endgenerate

    cal_stage #(
        .W    (WDAYW),
        .BCD  (1'b0),
        .MINV (3'd0),
        .RSTV (3'd0)
    ) u_wday (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (co[2]),
        .ld      (load_sel[WDAY_LD]),
        .ld_val  (load_val[WDAYW-1:0]),
        .max_val (3'd6),
        .q       (wday),
        .co      (wday_co)
    );

    assign secs       = q[0];
    assign mins       = q[1];
    assign hours      = q[2];
    assign mday       = q[3];
    assign month      = q[4];
    assign year       = q[5];
    assign year_carry = co[5];

    // weekday wrap has no consumer
    logic unused_ok;
    assign unused_ok = wday_co;

endmodule

// File: rtl/cal_chain_chk.sv
module cal_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [6:0] load_sel,
    input logic [7:0] load_val,
    input logic [7:0] secs,
    input logic [7:0] mins,
    input logic [7:0] hours,
    input logic [2:0] wday,
    input logic [7:0] mday,
    input logic [7:0] month,
    input logic [7:0] year,
    input logic       year_carry
);
    logic       midnight;
    logic [7:0] lim_chk;
    logic       leap_chk;

    always_comb begin
        midnight = tick && (load_sel == 7'd0) && secs == 8'h59 && mins == 8'h59 && hours == 8'h23;
        leap_chk = ((year[7:4] * 4'd10 + {4'd0, year[3:0]}) % 8'd4) == 8'd0;
        if (month == 8'h02)                                           lim_chk = leap_chk ? 8'h29 : 8'h28;
        else if (month == 8'h04 || month == 8'h06 || month == 8'h09 || month == 8'h11) lim_chk = 8'h30;
        else                                                          lim_chk = 8'h31;
    end

    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !load_sel[0] && secs == 8'h59 |=> secs == 8'h00);

    p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load_sel[0] |=> $stable(secs));

    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        midnight |=> hours == 8'h00 && mins == 8'h00);

    p_wday_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wday <= 3'd6);

    p_day_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        midnight && mday == lim_chk |=> mday == 8'h01);

    p_day_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        midnight && mday < lim_chk |=> $stable(month));

    p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        year_carry |=> year == 8'h00 && month == 8'h01 && mday == 8'h01);

    p_load_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_sel[0] |=> secs == $past(load_val));

    p_load_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_sel[0] && !load_sel[1] |=> $stable(mins));

endmodule

bind cal_chain cal_chain_chk u_chk (.*);

// File: tb/cal_chain_tb.sv
`timescale 1ns/100ps
module cal_chain_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [6:0] load_sel = '0;
    logic [7:0] load_val = '0;
    logic [7:0] secs, mins, hours, mday, month, year;
    logic [2:0] wday;
    logic       year_carry;

    always #2.5 clk = ~clk;

    cal_chain u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_sel(load_sel), .load_val(load_val),
        .secs(secs), .mins(mins), .hours(hours), .wday(wday), .mday(mday),
        .month(month), .year(year), .year_carry(year_carry)
    );

    typedef struct {
        int    s, m, h, w, d, mo, y;
        string tag;
    } exp_t;

    exp_t q_exp[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state (decimal)
    int rs = 0, rm = 0, rh = 0, rw = 0, rd = 1, rmo = 1, ry = 0;

    function automatic int tobcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int frombcd(int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // driver: applies one cycle and pushes the expected result
    task automatic step(input bit tk, input logic [6:0] ls, input int dat, input string tag);
        bit c0, c1, c2, c4, c5, yc;
        int dv, lim;
        exp_t e;
        @(negedge clk);
        tick = tk; load_sel = ls; load_val = dat[7:0];
        dv  = frombcd(dat);
        lim = days_in(rmo, ry);
        c0 = tk && !ls[0] && rs == 59;
        c1 = c0 && !ls[1] && rm == 59;
        c2 = c1 && !ls[2] && rh == 23;
        c4 = c2 && !ls[4] && rd >= lim;
        c5 = c4 && !ls[5] && rmo == 12;
        yc = c5 && !ls[6] && ry == 99;
        #1;
        total++;
        if (year_carry !== yc) begin
            bad++;
            $display("FAIL R7 %s year_carry actual=%0b expected=%0b", tag, year_carry, yc);
        end
        if (ls[0]) rs = dv; else if (tk) rs = (rs == 59) ? 0 : rs + 1;
        if (ls[1]) rm = dv; else if (c0) rm = (rm == 59) ? 0 : rm + 1;
        if (ls[2]) rh = dv; else if (c1) rh = (rh == 23) ? 0 : rh + 1;
        if (ls[3]) rw = dat & 7; else if (c2) rw = (rw == 6) ? 0 : rw + 1;
        if (ls[4]) rd = dv; else if (c2) rd = (rd >= lim) ? 1 : rd + 1;
        if (ls[5]) rmo = dv; else if (c4) rmo = (rmo == 12) ? 1 : rmo + 1;
        if (ls[6]) ry = dv; else if (c5) ry = (ry == 99) ? 0 : ry + 1;
        e.s = rs; e.m = rm; e.h = rh; e.w = rw; e.d = rd; e.mo = rmo; e.y = ry; e.tag = tag;
        q_exp.push_back(e);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            total++;
            if (secs !== 8'(tobcd(e.s)) || mins !== 8'(tobcd(e.m)) || hours !== 8'(tobcd(e.h)) ||
                wday !== 3'(e.w) || mday !== 8'(tobcd(e.d)) || month !== 8'(tobcd(e.mo)) ||
                year !== 8'(tobcd(e.y))) begin
                bad++;
                $display("FAIL %s actual=%h:%h:%h w%0d %h/%h/%h expected=%h:%h:%h w%0d %h/%h/%h",
                         e.tag, secs, mins, hours, wday, mday, month, year,
                         8'(tobcd(e.h)), 8'(tobcd(e.m)), 8'(tobcd(e.s)), e.w,
                         8'(tobcd(e.d)), 8'(tobcd(e.mo)), 8'(tobcd(e.y)));
            end
        end
    end

    task automatic preset_midnight(input int d, input int mo, input int y);
        step(0, 7'b0010000, tobcd(d),  "R8 load mday");
        step(0, 7'b0100000, tobcd(mo), "R8 load month");
        step(0, 7'b1000000, tobcd(y),  "R8 load year");
        step(0, 7'b0000001, 8'h59, "R8 load secs");
        step(0, 7'b0000010, 8'h59, "R8 load mins");
        step(0, 7'b0000100, 8'h23, "R8 load hours");
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        total++;
        if (secs !== 8'h00 || mins !== 8'h00 || hours !== 8'h00 || wday !== 3'd0 ||
            mday !== 8'h01 || month !== 8'h01 || year !== 8'h00 || year_carry !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset actual=%h:%h:%h w%0d %h/%h/%h expected=00:00:00 w0 01/01/00",
                     hours, mins, secs, wday, mday, month, year);
        end

        // R2: counting and holding
        for (int i = 0; i < 12; i++) step(1, 0, 0, "R2 tick count");
        for (int i = 0; i < 3; i++)  step(0, 0, 0, "R2 hold");
        step(0, 7'b0000001, 8'h58, "R8 load secs");
        step(1, 0, 0, "R2 to 59");
        step(1, 0, 0, "R2 wrap carry");

        // R3: minute and hour carries
        step(0, 7'b0000010, 8'h59, "R8 load mins");
        step(0, 7'b0000001, 8'h59, "R8 load secs");
        step(1, 0, 0, "R3 minute wrap");

        // R4/R5: midnight rollover, BCD day digit roll
        preset_midnight(9, 5, 23);
        step(1, 0, 0, "R5 day 09 to 10");
        step(0, 7'b0001000, 6, "R8 load wday");
        preset_midnight(15, 5, 23);
        step(1, 0, 0, "R4 wday 6 to 0");

        // R6: each month's last day, common year, and one short of it
        for (int mo = 1; mo <= 12; mo++) begin
            preset_midnight(days_in(mo, 23) - 1, mo, 23);
            step(1, 0, 0, "R6 last-1 no wrap");
            preset_midnight(days_in(mo, 23), mo, 23);
            step(1, 0, 0, "R6 month end wrap");
        end
        // R6: leap Februaries
        preset_midnight(28, 2, 24);
        step(1, 0, 0, "R6 feb28 leap 24");
        preset_midnight(28, 2, 0);
        step(1, 0, 0, "R6 feb28 leap 00");
        preset_midnight(29, 2, 0);
        step(1, 0, 0, "R6 feb29 wrap 00");

        // R7: year end, with and without century wrap
        preset_midnight(31, 12, 41);
        step(1, 0, 0, "R7 dec31 year+1");
        preset_midnight(31, 12, 99);
        step(1, 0, 0, "R7 year 99 wrap");

        // R8: load against carry
        step(0, 7'b0000001, 8'h59, "R8 load secs");
        step(1, 7'b0000001, 8'h30, "R8 load beats tick");
        preset_midnight(20, 3, 50);
        step(1, 7'b0010000, 8'h07, "R8 load beats day carry");
        preset_midnight(31, 12, 99);
        step(1, 7'b1000000, 8'h99, "R8 load blocks year carry");

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule